// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Byte-Addressable Read Port

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter. A host starts a conversion through five control inputs. They are a chip enable, an active-low chip select, a read/convert line, a byte-address line and a data-width select. During a conversion the block walks a trial code from the most significant bit downward. It presents each trial code to an external DAC and keeps or clears the trial bit according to a single comparator input. While it works it holds a busy flag high.

The byte-address line has two roles. At the start of a conversion it selects a full 12-bit conversion or a short 8-bit one. During a read it selects which byte a narrow bus receives. A host with a 16-bit or wider bus reads the whole result at once. An 8-bit host reads a left-justified high byte and then a low nibble padded with zeros. Three-state pins are modelled as a data word together with an output-enable flag. With chip enable and width select tied high and chip select and byte address tied low, the read/convert line alone operates the block.

Top module: `sar_ctrl_top`

## Requirements
- R1: The start level is true while chip_en=1, chip_sel_n=0 and rd_conv=0. A conversion starts on the clock where this level goes from false to true. The starting change can therefore be a rising chip_en, a falling chip_sel_n or a falling rd_conv, whichever completes the level last.
- R2: byte_sel sampled at the start clock sets the conversion length. byte_sel=0 gives 12 bits and byte_sel=1 gives an 8-bit short cycle.
- R3: data_oe is 1 only while chip_en=1, chip_sel_n=0, rd_conv=1 and busy=0. Otherwise data_oe is 0 and data_out is all zeros.
- R4: With wide_rd=1 during a read, data_out carries the whole 12-bit result and byte_sel has no effect.
- R5: With wide_rd=0 and byte_sel=0 during a read, data_out[11:4] carries result bits 11..4 and data_out[3:0] is zero.
- R6: With wide_rd=0 and byte_sel=1 during a read, data_out[11:8] carries result bits 3..0 and data_out[7:0] is zero.
- R7: The result is straight binary and equals the largest code not above the input level. A 12-bit conversion holds busy high for exactly 12 clocks and a short cycle for exactly 8.
- R8: With chip_en=1, chip_sel_n=0, wide_rd=1 and byte_sel=0 fixed, each low pulse on rd_conv starts a 12-bit conversion. The whole word appears once rd_conv is high and busy has fallen.
- R9: busy rises in the clock after the start clock. A start level that rises while busy is high is ignored and does not restart or lengthen the conversion.
- R10: The first trial code presented on dac_code is 0x800. Each clock after that, the current trial bit is kept when cmp_in=1 (input at or above the trial) and cleared otherwise, and the next lower bit is set.
- R11: A short cycle decides bits 11..4 only and yields result bits 3..0 as zero. The result register changes only when a conversion completes.
- R12: An active-low synchronous reset clears the result, busy and the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | 1 = read, 0 = convert |
| byte_sel | input | 1 | Short-cycle select at start; byte select on narrow reads |
| wide_rd | input | 1 | 1 = whole-word read, 0 = byte read |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above dac_code |
| dac_code | output | 12 | Current trial code for the DAC |
| busy | output | 1 | High while a conversion runs |
| data_out | output | 12 | Read data, zero when not enabled |
| data_oe | output | 1 | Stands in for the enable of three-state data pins |

## Verification
The bench models the comparator from a chosen input level. It covers the extreme levels 0x000 and 0xFFF, a level sitting exactly on a trial code, and a short-cycle level with nonzero low bits. A design that counted bits wrongly would return a result off by one bit or would hold busy for the wrong number of clocks. A design that did not pad short results would leak the low bits.

Each of the three starting edges is exercised, and a second start edge is raised in the middle of a conversion. A controller that retriggered on that edge would extend busy. Reads are also attempted while busy, and in each byte mode. A design that gated the output on the control lines alone would drive stale data mid-conversion. A design with swapped or unshifted bytes would return the wrong nibble position.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DEF_RES_W   = 12;
  localparam int unsigned DEF_SHORT_W = 8;
  localparam int unsigned DEF_BYTE_W  = 8;

  typedef enum logic [1:0] {
    RD_OFF  = 2'd0,
    RD_WORD = 2'd1,
    RD_HIGH = 2'd2,
    RD_LOW  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic chip_sel_n,
  input  logic rd_conv,
  input  logic busy,
  output logic start_evt
);
  logic lvl, lvl_q;

  // all three enables must agree; whichever arrives last forms the edge
  assign lvl = chip_en & ~chip_sel_n & ~rd_conv;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign start_evt = lvl & ~lvl_q & ~busy;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned WIDTH      = 12,
  parameter int unsigned SHORT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             short_req,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done_evt,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result
);
  localparam int unsigned IDX_W    = $clog2(WIDTH);
  localparam int unsigned PAD_BITS = WIDTH - SHORT_BITS;

  logic             busy_q, short_q;
  logic [IDX_W-1:0] idx_q, stop_idx;
  logic [WIDTH-1:0] work_q, result_q, decided;

  function automatic logic [WIDTH-1:0] bit_at(input logic [IDX_W-1:0] i);
    return WIDTH'(1) << i;
  endfunction

  // keep the trial bit when the input is at or above the trial level
  function automatic logic [WIDTH-1:0] keep_or_clear(
    input logic [WIDTH-1:0] code, input logic [IDX_W-1:0] i, input logic keep);
    return keep ? code : (code & ~bit_at(i));
  endfunction

  function automatic logic [WIDTH-1:0] pad_short(
    input logic [WIDTH-1:0] code, input logic is_short);
    logic [WIDTH-1:0] mask;
    mask = ~((WIDTH'(1) << PAD_BITS) - WIDTH'(1));
    return is_short ? (code & mask) : code;
  endfunction

  assign stop_idx = short_q ? IDX_W'(PAD_BITS) : '0;
  assign done_evt = busy_q && (idx_q == stop_idx);
  assign decided  = keep_or_clear(work_q, idx_q, cmp_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      short_q  <= 1'b0;
      idx_q    <= '0;
      work_q   <= '0;
      result_q <= '0;
    end else if (start_evt) begin
      busy_q  <= 1'b1;
      short_q <= short_req;
      idx_q   <= IDX_W'(WIDTH - 1);
      work_q  <= bit_at(IDX_W'(WIDTH - 1));
    end else if (busy_q) begin
      if (done_evt) begin
        busy_q   <= 1'b0;
        work_q   <= decided;
        result_q <= pad_short(decided, short_q);
      end else begin
        idx_q  <= idx_q - IDX_W'(1);
        work_q <= decided | bit_at(idx_q - IDX_W'(1));
      end
    end
  end

  assign busy   = busy_q;
  assign trial  = work_q;
  assign result = result_q;
endmodule

// File: rtl/sar_read_mux.sv
module sar_read_mux
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned BYTE_W = 8
) (
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_conv,
  input  logic             busy,
  input  logic             wide_rd,
  input  logic             byte_sel,
  input  logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] data_out,
  output logic             data_oe
);
  localparam int unsigned LOW_W = WIDTH - BYTE_W;

  rd_sel_e sel;

  // byte lanes sit on the upper BYTE_W lines, left-justified
  function automatic logic [WIDTH-1:0] lane(input rd_sel_e s, input logic [WIDTH-1:0] r);
    case (s)
      RD_WORD: return r;
      RD_HIGH: return {r[WIDTH-1 -: BYTE_W], {LOW_W{1'b0}}};
      RD_LOW:  return {r[LOW_W-1:0], {BYTE_W{1'b0}}};
      default: return '0;
    endcase
  endfunction

  assign data_oe = chip_en & ~chip_sel_n & rd_conv & ~busy;

  always_comb begin
    if (!data_oe)     sel = RD_OFF;
    else if (wide_rd) sel = RD_WORD;
    else if (byte_sel) sel = RD_LOW;
    else              sel = RD_HIGH;
  end

  assign data_out = lane(sel, result);
endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH      = DEF_RES_W,
  parameter int unsigned SHORT_BITS = DEF_SHORT_W,
  parameter int unsigned BYTE_W     = DEF_BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_conv,
  input  logic             byte_sel,
  input  logic             wide_rd,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic [WIDTH-1:0] data_out,
  output logic             data_oe
);
  logic             start_evt;
  logic             done_evt;
  logic [WIDTH-1:0] result_q;

  sar_start_detect u_start (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_conv(rd_conv), .busy(busy), .start_evt(start_evt)
  );

  sar_seq #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .short_req(byte_sel),
    .cmp_in(cmp_in), .busy(busy), .done_evt(done_evt), .trial(dac_code),
    .result(result_q)
  );

  sar_read_mux #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_rd (
    .chip_en(chip_en), .chip_sel_n(chip_sel_n), .rd_conv(rd_conv), .busy(busy),
    .wide_rd(wide_rd), .byte_sel(byte_sel), .result(result_q),
    .data_out(data_out), .data_oe(data_oe)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             done_evt,
  input logic             busy,
  input logic             data_oe,
  input logic             wide_rd,
  input logic             byte_sel,
  input logic [WIDTH-1:0] data_out,
  input logic [WIDTH-1:0] result_q
);
  localparam int unsigned CW = $clog2(WIDTH) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + CW'(1);
  end

  a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);
  a_r3_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_oe);
  a_r4_word: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && wide_rd) |-> (data_out == result_q));
  a_r6_low_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !wide_rd && byte_sel) |-> (data_out[WIDTH-BYTE_W-1:0] == '0));
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < CW'(WIDTH)));
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(result_q));
endmodule

bind sar_ctrl_top sar_ctrl_chk #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .done_evt(done_evt),
  .busy(busy), .data_oe(data_oe), .wide_rd(wide_rd), .byte_sel(byte_sel),
  .data_out(data_out), .result_q(result_q)
);

// File: tb/sim_sar_ctrl_top.sv
module sim_sar_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_en = 1'b0, chip_sel_n = 1'b1, rd_conv = 1'b1;
  logic        byte_sel = 1'b0, wide_rd = 1'b1;
  logic        cmp_in;
  logic [11:0] dac_code, data_out;
  logic        busy, data_oe;
  logic [11:0] vin = '0;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  typedef struct { logic oe; logic [11:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  logic strobe = 1'b0;

  always #5 clk = ~clk;

  // comparator model: input at or above trial level gives 1
  assign cmp_in = (vin >= dac_code);

  sar_ctrl_top u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_conv(rd_conv), .byte_sel(byte_sel), .wide_rd(wide_rd), .cmp_in(cmp_in),
    .dac_code(dac_code), .busy(busy), .data_out(data_out), .data_oe(data_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when the driver flags a read
  always @(negedge clk) begin
    if (strobe && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(data_oe == e.oe, {e.tag, " oe"}, data_oe, e.oe);
      check(data_out == e.val, {e.tag, " data"}, data_out, e.val);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic read_exp(input bit w, input bit b, input logic oe,
                          input logic [11:0] v, input string tag);
    exp_t e;
    chip_en = 1; chip_sel_n = 0; rd_conv = 1; wide_rd = w; byte_sel = b;
    e.oe = oe; e.val = v; e.tag = tag;
    exp_q.push_back(e);
    strobe = 1;
    @(negedge clk);
    tick();
    strobe = 0;
  endtask

  // waits for busy to clear; returns busy clocks counted at negedges
  task automatic wait_done(output int n, output logic [11:0] first_trial);
    n = 0; first_trial = '0;
    @(negedge clk);
    while (busy && n < 40) begin
      if (n == 0) first_trial = dac_code;
      n++;
      @(negedge clk);
    end
    tick();
  endtask

  // kind 0: falling rd_conv, 1: falling chip_sel_n, 2: rising chip_en
  task automatic convert(input logic [11:0] v, input bit shrt, input int kind,
                         input string tag);
    int n; logic [11:0] ft;
    vin = v; byte_sel = shrt;
    case (kind)
      0: begin chip_en = 1; chip_sel_n = 0; rd_conv = 1; tick(); rd_conv = 0; end
      1: begin chip_en = 1; chip_sel_n = 1; rd_conv = 0; tick(); chip_sel_n = 0; end
      default: begin chip_en = 0; chip_sel_n = 0; rd_conv = 0; tick(); chip_en = 1; end
    endcase
    tick();
    byte_sel = 0; rd_conv = 1;
    wait_done(n, ft);
    check(ft == 12'h800, {tag, " R10 first trial"}, ft, 12'h800);
    check(n == (shrt ? 8 : 12), {tag, " R7 busy length"}, n, shrt ? 8 : 12);
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n; logic [11:0] ft;
    repeat (3) tick();
    // R12: reset state
    check(busy == 0, "R12 busy after reset", busy, 0);
    rst_n = 1; tick();
    read_exp(1, 0, 1, 12'h000, "R12 result cleared");

    // R1 + R7: three start edges, several levels
    convert(12'hABC, 0, 0, "R1 rd_conv edge");
    read_exp(1, 0, 1, 12'hABC, "R7 word ABC");
    convert(12'hFFF, 0, 1, "R1 chip_sel edge");
    read_exp(1, 1, 1, 12'hFFF, "R4 word ignores byte_sel");
    convert(12'h000, 0, 2, "R1 chip_en edge");
    read_exp(1, 0, 1, 12'h000, "R7 zero level");
    convert(12'h800, 0, 0, "R10 on trial");
    read_exp(1, 0, 1, 12'h800, "R10 exact trial kept");

    // R5/R6 byte reads
    convert(12'h5A3, 0, 0, "R5 setup");
    read_exp(0, 0, 1, 12'h5A0, "R5 high byte");
    read_exp(0, 1, 1, 12'h300, "R6 low nibble");

    // R2/R11: short cycle drops low bits
    convert(12'h7C9, 1, 1, "R2 short");
    read_exp(1, 0, 1, 12'h7C0, "R11 short pad");
    read_exp(0, 1, 1, 12'h000, "R6 short low byte");

    // R3: gating off with chip_sel_n high, and with chip_en low
    chip_en = 1; chip_sel_n = 1; rd_conv = 1; @(negedge clk);
    check(data_oe == 0 && data_out == 0, "R3 cs high", data_oe, 0);
    tick(); chip_en = 0; chip_sel_n = 0; @(negedge clk);
    check(data_oe == 0, "R3 ce low", data_oe, 0);
    tick();

    // R9/R3/R11: restart attempt and read while busy
    vin = 12'h123; byte_sel = 0;
    chip_en = 1; chip_sel_n = 0; rd_conv = 1; tick(); rd_conv = 0; tick();
    rd_conv = 1; @(negedge clk);
    check(busy == 1, "R9 busy next clock", busy, 1);
    check(data_oe == 0, "R3 read blocked busy", data_oe, 0);
    tick(); rd_conv = 0; tick(); rd_conv = 1; tick();
    n = 3;
    while (busy && n < 40) begin n++; tick(); end
    check(n == 12, "R9 restart ignored", n, 12);
    read_exp(1, 0, 1, 12'h123, "R9 result after ignore");

    // R8: standalone, rd_conv only
    chip_en = 1; chip_sel_n = 0; wide_rd = 1; byte_sel = 0; vin = 12'h9E7;
    rd_conv = 0; tick(); rd_conv = 1;
    @(negedge clk);
    check(data_oe == 0, "R8 no data while busy", data_oe, 0);
    tick();
    while (busy) tick();
    read_exp(1, 0, 1, 12'h9E7, "R8 standalone word");

    // R12: reset mid-conversion
    vin = 12'h456; rd_conv = 0; tick(); rd_conv = 1; tick(); tick();
    rst_n = 0; tick(); rst_n = 1; @(negedge clk);
    check(busy == 0, "R12 busy cleared", busy, 0);
    tick();
    read_exp(1, 0, 1, 12'h000, "R12 result cleared mid");

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule